// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel flash and decides when a program or erase has finished inside the device. Software or a sequencer hands it one request: the operation type, the target address and the byte that was written. The poller then checks the device again and again until it sees completion, and reports the result with a single-cycle done pulse.

Three ways of detecting completion can be chosen per request. The first watches bit 7 of a status read at the target address. The second compares bit 6 across consecutive reads. The third looks at the device's ready/busy pin. A programmable gap separates the checks. Bit 7 can become valid while the lower bits are still settling. For that reason, every completion is confirmed by one more full read at the target address, and that byte is the one reported. If completion is not seen within a fixed number of checks, the poller stops and flags a timeout.

Top module: `flash_done_poller`

## Requirements
- R1: After reset the poller is idle. `busy_o`, `rd_req_o`, `done_o` and `timeout_o` are low and `poll_cnt_o` is 0.
- R2: A start is accepted only while `busy_o` is low. A start pulse while busy changes neither the running operation nor its result, and produces no extra done pulse. No read is requested while idle.
- R3: Between the acknowledge of one status read and the next read request, the poller waits the gap given at start. The next request rises exactly `gap_i + 3` cycles after the previous one rose, when the read port acknowledges one cycle after seeing the request.
- R4: Every read uses the target address given at start. With `mode_i` = 0 (bit-7 polling) and `op_i` = 0 (program), a status read is complete when its bit 7 equals bit 7 of the expected byte.
- R5: With `mode_i` = 0 and `op_i` = 1 (erase), a status read is complete when its bit 7 is 1.
- R6: After completion is seen, one more read is made at the target address. `result_o` holds that byte when `done_o` pulses, not the status byte that showed completion.
- R7: With `mode_i` = 1 (bit-6 toggle), completion is seen when bit 6 of a status read equals bit 6 of the previous status read of the same operation. The first read of an operation never completes.
- R8: With `mode_i` = 2 or 3 (pin), the poller samples `rdy_pin_i` after each gap without a read. High means done and low means busy. Only the confirming read is issued.
- R9: `poll_cnt_o` counts the status checks (reads or pin samples) of the current operation, including the check that saw completion. The confirming read is not counted. The count is cleared at start and held after done.
- R10: If `MAX_POLLS` checks pass without completion, `done_o` pulses with `timeout_o` high in the same cycle. `poll_cnt_o` then equals `MAX_POLLS`, and `result_o` holds the last status byte, or 0 in pin mode.
- R11: `done_o` and `timeout_o` are high for exactly one cycle per accepted operation.
- R12: `rd_req_o` stays high with a stable `rd_addr_o` until `rd_ack_i` is seen. `rd_data_i` is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only while idle |
| op_i | input | 1 | 0 program, 1 erase |
| mode_i | input | 2 | 0 bit-7 polling, 1 bit-6 toggle, 2/3 ready pin |
| addr_i | input | AW | Target address |
| data_i | input | 8 | Expected byte (bit 7 used for program polling) |
| gap_i | input | GW | Idle cycles between checks |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 8 | Read data |
| rdy_pin_i | input | 1 | Device ready/busy pin, high = ready |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Completion not seen, valid with done |
| result_o | output | 8 | Reported byte |
| poll_cnt_o | output | CW | Status checks made |

## Verification
The bench models a device whose status reads differ from its final data. A design that reported the status byte instead of making the confirming read returns a wrong result. A design that treated erase like program, or compared bit 7 against the wrong value, ends early or late, so both the check count and the byte come out wrong. In toggle mode the first read has no predecessor, and a design that compared it against a stale bit 6 would finish one check early. Timeouts in every mode, a start pulse in the middle of an operation and the measured spacing of requests catch wrong limit logic, a re-armed operation and an off-by-one gap.

// File: rtl/fpoll_pkg.sv
// Shared definitions for the flash completion poller.
// Assumes: mode codes are fixed, since software encodes them.
package fpoll_pkg;
    localparam logic [1:0] MODE_DATA   = 2'd0;
    localparam logic [1:0] MODE_TOGGLE = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_POLL,
        ST_FINAL
    } fpoll_state_t;
endpackage

// File: rtl/poll_gap_timer.sv
// Down-counter that spaces out completion checks.
// Assumes: a load takes priority, and the counter rests at zero.
module poll_gap_timer #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [GW-1:0] val_i,
    output logic          zero_o
);
    logic [GW-1:0] cnt_q;

    // Load a new gap or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load_i)      cnt_q <= val_i;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/poll_judge.sv
// Decides from one check whether the device has finished.
// Assumes: the caller presents the check only in the cycle it is valid.
module poll_judge
    import fpoll_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       erase_i,
    input  logic       exp7_i,
    input  logic       bit7_i,
    input  logic       bit6_i,
    input  logic       prev6_i,
    input  logic       have_prev_i,
    input  logic       pin_i,
    output logic       complete_o
);
    // Pick the completion rule for the selected mode.
    always_comb begin
        if (mode_i[1])
            complete_o = pin_i;
        else if (mode_i == MODE_TOGGLE)
            complete_o = have_prev_i && (bit6_i == prev6_i);
        else if (erase_i)
            complete_o = bit7_i;
        else
            complete_o = (bit7_i == exp7_i);
    end
endmodule

// File: rtl/flash_done_poller.sv
// Flash completion poller. Takes one request while idle, repeats status
// checks spaced by a gap, confirms completion with a full read at the
// target address and pulses done. Stops with a timeout after MAX_POLLS
// checks. Assumes the read port holds rd_data_i valid with rd_ack_i.
module flash_done_poller
    import fpoll_pkg::*;
#(
    parameter int AW        = 24,
    parameter int GW        = 8,
    parameter int MAX_POLLS = 1000,
    localparam int CW       = $clog2(MAX_POLLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          op_i,
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    input  logic [GW-1:0] gap_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [7:0]    rd_data_i,
    input  logic          rdy_pin_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          timeout_o,
    output logic [7:0]    result_o,
    output logic [CW-1:0] poll_cnt_o
);
    fpoll_state_t  state_q;
    logic          erase_q, exp7_q, prev6_q, have_prev_q;
    logic [1:0]    mode_q;
    logic [AW-1:0] addr_q;
    logic [GW-1:0] gap_q;
    logic [CW-1:0] cnt_q, cnt_next;
    logic          gap_zero, complete, step, at_limit, retry, tmr_load;
    logic [GW-1:0] tmr_val;

    poll_gap_timer #(.GW(GW)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (gap_zero)
    );

    poll_judge u_judge (
        .mode_i      (mode_q),
        .erase_i     (erase_q),
        .exp7_i      (exp7_q),
        .bit7_i      (rd_data_i[7]),
        .bit6_i      (rd_data_i[6]),
        .prev6_i     (prev6_q),
        .have_prev_i (have_prev_q),
        .pin_i       (rdy_pin_i),
        .complete_o  (complete)
    );

    // Decide when a check happens, whether to retry, and when to reload the gap.
    always_comb begin
        step     = (state_q == ST_GAP && gap_zero && mode_q[1]) ||
                   (state_q == ST_POLL && rd_ack_i);
        cnt_next = cnt_q + 1'b1;
        at_limit = (cnt_next == CW'(MAX_POLLS));
        retry    = step && !complete && !at_limit;
        tmr_load = (state_q == ST_IDLE && start_i) || retry;
        tmr_val  = (state_q == ST_IDLE) ? gap_i : gap_q;
    end

    // Sequence the operation: accept, wait, check, confirm, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            erase_q     <= 1'b0;
            exp7_q      <= 1'b0;
            mode_q      <= MODE_DATA;
            addr_q      <= '0;
            gap_q       <= '0;
            cnt_q       <= '0;
            prev6_q     <= 1'b0;
            have_prev_q <= 1'b0;
            done_o      <= 1'b0;
            timeout_o   <= 1'b0;
            result_o    <= '0;
        end else begin
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        erase_q     <= op_i;
                        exp7_q      <= data_i[7];
                        mode_q      <= mode_i;
                        addr_q      <= addr_i;
                        gap_q       <= gap_i;
                        cnt_q       <= '0;
                        have_prev_q <= 1'b0;
                        state_q     <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_zero && !mode_q[1]) state_q <= ST_POLL;
                end
                ST_POLL: begin
                    if (rd_ack_i) begin
                        prev6_q     <= rd_data_i[6];
                        have_prev_q <= 1'b1;
                    end
                end
                ST_FINAL: begin
                    if (rd_ack_i) begin
                        result_o <= rd_data_i;
                        done_o   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (step) begin
                cnt_q <= cnt_next;
                if (complete) begin
                    state_q <= ST_FINAL;
                end else if (at_limit) begin
                    result_o  <= mode_q[1] ? 8'h00 : rd_data_i;
                    done_o    <= 1'b1;
                    timeout_o <= 1'b1;
                    state_q   <= ST_IDLE;
                end else begin
                    state_q <= ST_GAP;
                end
            end
        end
    end

    assign rd_req_o   = (state_q == ST_POLL) || (state_q == ST_FINAL);
    assign rd_addr_o  = addr_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign poll_cnt_o = cnt_q;
endmodule

// Protocol checker for the poller, attached below with bind.
module fpoll_checker #(
    parameter int AW = 24,
    parameter int MAX_POLLS = 1000,
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req_o,
    input logic          rd_ack_i,
    input logic [AW-1:0] rd_addr_o,
    input logic [AW-1:0] addr_q,
    input logic          busy_o,
    input logic          done_o,
    input logic          timeout_o,
    input logic [CW-1:0] poll_cnt_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11
    AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> done_o); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o); // R2
    AST_ADDR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> rd_addr_o == addr_q); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt_o <= CW'(MAX_POLLS)); // R9
endmodule

bind flash_done_poller fpoll_checker #(.AW(AW), .MAX_POLLS(MAX_POLLS), .CW(CW)) u_fpoll_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req_o   (rd_req_o),
    .rd_ack_i   (rd_ack_i),
    .rd_addr_o  (rd_addr_o),
    .addr_q     (addr_q),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .timeout_o  (timeout_o),
    .poll_cnt_o (poll_cnt_o)
);

// File: tb/test_flash_done_poller.sv
// Scoreboard bench: the driver queues expected results, the monitor
// compares each done pulse, and a device model answers reads.
module test_flash_done_poller;
    localparam int AW = 16, GW = 4, MAXP = 8, CW = $clog2(MAXP + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, op_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0] data_i = '0;
    logic [GW-1:0] gap_i = '0;
    logic rd_req_o, rd_ack_i, rdy_pin_i, busy_o, done_o, timeout_o;
    logic [AW-1:0] rd_addr_o;
    logic [7:0] rd_data_i, result_o;
    logic [CW-1:0] poll_cnt_o;

    flash_done_poller #(.AW(AW), .GW(GW), .MAX_POLLS(MAXP)) i_flash_done_poller (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .mode_i(mode_i),
        .addr_i(addr_i), .data_i(data_i), .gap_i(gap_i), .rd_req_o(rd_req_o),
        .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .rdy_pin_i(rdy_pin_i), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
        .result_o(result_o), .poll_cnt_o(poll_cnt_o)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Device model settings, written by the driver only.
    logic m_op = 1'b0;
    logic [1:0] m_mode = 2'd0;
    logic [7:0] m_exp = 8'h00, m_full = 8'h00;
    logic [AW-1:0] m_addr = '0;
    int m_b = 0, m_done = 0;
    logic pin_drv = 1'b0;
    assign rdy_pin_i = pin_drv;

    function automatic logic [7:0] model_byte(input int idx);
        logic b6, dbit, b7;
        if (idx > m_done) return m_full;
        if (m_mode == 2'd1) begin
            b6 = (idx <= m_b) ? idx[0] : m_b[0];
            return 8'h11 | {1'b0, b6, 6'b0};
        end
        dbit = m_op ? 1'b1 : m_exp[7];
        b7 = (idx < m_b) ? ~dbit : dbit;
        return {b7, 7'h2A};
    endfunction

    // Read port model: acknowledge one cycle after a request, and check the address.
    int m_idx = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_ack_i <= 1'b0;
            rd_data_i <= '0;
            m_idx <= 0;
        end else begin
            rd_ack_i <= 1'b0;
            if (start_i && !busy_o) m_idx <= 0;
            else if (rd_req_o && !rd_ack_i) begin
                rd_ack_i <= 1'b1;
                rd_data_i <= model_byte(m_idx);
                m_idx <= m_idx + 1;
                chk(rd_addr_o == m_addr, "R4/R12", "read address", int'(rd_addr_o), int'(m_addr));
            end
        end
    end

    // Request rise timing, for the gap check.
    logic req_d = 1'b0;
    int rise_n = 0, rise0 = 0, rise1 = 0;
    always @(negedge clk) begin
        if (start_i && !busy_o) rise_n <= 0;
        else if (rd_req_o && !req_d) begin
            if (rise_n == 0) rise0 <= cyc;
            if (rise_n == 1) rise1 <= cyc;
            rise_n <= rise_n + 1;
        end
        req_d <= rd_req_o;
    end

    typedef struct { logic [7:0] res; logic to; int polls; string tag; } exp_t;
    exp_t sb[$];

    // Monitor: compare each done pulse with the oldest expected item.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R2/R11", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(result_o == e.res, e.tag, "result", result_o, e.res);
                    chk(timeout_o == e.to, "R10", "timeout flag", timeout_o, e.to);
                    chk(int'(poll_cnt_o) == e.polls, "R9", "check count", poll_cnt_o, e.polls);
                    @(negedge clk);
                    chk(!done_o && !timeout_o, "R11", "done width", done_o, 0);
                end
            end
        end
    end

    task automatic pulse_start(input logic op, input logic [1:0] md, input logic [AW-1:0] a,
                               input logic [7:0] d, input logic [GW-1:0] g);
        op_i = op; mode_i = md; addr_i = a; data_i = d; gap_i = g;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_op(input logic op, input logic [1:0] md, input logic [AW-1:0] a,
                          input logic [7:0] d, input logic [GW-1:0] g, input int b,
                          input logic [7:0] full, input logic [7:0] eres, input logic eto,
                          input int epolls, input string tag);
        exp_t e;
        m_op = op; m_mode = md; m_exp = d; m_addr = a; m_b = b; m_full = full;
        m_done = md[1] ? -1 : (md == 2'd1 ? b + 1 : b);
        e.res = eres; e.to = eto; e.polls = epolls; e.tag = tag;
        sb.push_back(e);
        pulse_start(op, md, a, d, g);
        do @(negedge clk); while (sb.size() != 0 || busy_o);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !rd_req_o && !done_o && !timeout_o && poll_cnt_o == 0,
            "R1", "reset state", {busy_o, rd_req_o, done_o, timeout_o}, 0);
        // R4 program polling: 3 busy checks, the 4th matches, then a confirming read
        run_op(1'b0, 2'd0, 16'h1234, 8'hA5, 4'd2, 3, 8'hA5, 8'hA5, 1'b0, 4, "R4/R6");
        // R4 expected bit 7 = 0, complete on the first check
        run_op(1'b0, 2'd0, 16'h0042, 8'h3C, 4'd0, 0, 8'h3C, 8'h3C, 1'b0, 1, "R4/R6");
        // R5 erase: bit 7 must read 1, final byte 0xFF
        run_op(1'b1, 2'd0, 16'h8000, 8'h00, 4'd1, 2, 8'hFF, 8'hFF, 1'b0, 3, "R5/R6");
        // R7 toggle: 4 toggling reads, the 5th equals the 4th
        run_op(1'b0, 2'd1, 16'h0777, 8'h5E, 4'd1, 3, 8'h5E, 8'h5E, 1'b0, 5, "R7");
        chk(rise1 - rise0 == 1 + 3, "R3", "request spacing", rise1 - rise0, 4);
        // R8 pin high: a single pin check, then the confirming read
        pin_drv = 1'b1;
        run_op(1'b0, 2'd2, 16'h0100, 8'h77, 4'd2, 0, 8'h77, 8'h77, 1'b0, 1, "R8");
        // R8/R10 pin low throughout: timeout, result 0
        pin_drv = 1'b0;
        run_op(1'b0, 2'd3, 16'h0101, 8'h77, 4'd1, 0, 8'h77, 8'h00, 1'b1, MAXP, "R8/R10");
        // R10 polling never completes: last status byte reported
        run_op(1'b0, 2'd0, 16'h2222, 8'h80, 4'd0, 100, 8'h80, 8'h2A, 1'b1, MAXP, "R10");
        // R10 toggle never settles: read 7 has bit 6 = 1
        run_op(1'b0, 2'd1, 16'h3333, 8'h00, 4'd0, 100, 8'h00, 8'h51, 1'b1, MAXP, "R10");
        // R2 start while busy is ignored
        begin
            exp_t e;
            m_op = 1'b0; m_mode = 2'd0; m_exp = 8'hC3; m_addr = 16'h4444; m_b = 2;
            m_full = 8'hC3; m_done = 2;
            e.res = 8'hC3; e.to = 1'b0; e.polls = 3; e.tag = "R2";
            sb.push_back(e);
            pulse_start(1'b0, 2'd0, 16'h4444, 8'hC3, 4'd3);
            repeat (3) @(negedge clk);
            chk(busy_o, "R2", "busy during run", busy_o, 1);
            pulse_start(1'b1, 2'd1, 16'h5555, 8'h00, 4'd0);
            do @(negedge clk); while (sb.size() != 0 || busy_o);
            repeat (10) @(negedge clk);
            chk(!busy_o && !rd_req_o, "R2", "idle after run", {busy_o, rd_req_o}, 0);
            chk(poll_cnt_o == 3, "R9", "count held after done", poll_cnt_o, 3);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule